// File: doc/BRIEF.md
# Multi-Channel General-Purpose Timer

A register-mapped peripheral holding six independent up-counting timer channels. Each channel has its own counter and compare value, and it runs in one of three modes. In one-shot mode it stops at the first match. In repeat mode it restarts from zero after every match. In free-run mode it keeps counting through the match, so its count can be read at any moment as a monotonic timestamp.

Each channel counts single-cycle tick strobes. It takes them either from a fast system tick or from a slow real-time tick, and it can halve that rate with a divide-by-two option. Both strobes arrive in the system clock domain. A compare match sets a per-channel pending flag. A shared interrupt line is raised when any pending flag is also enabled in a global mask. Software clears pending flags by writing ones to an acknowledge register.

Register access is single-cycle. Writes take effect on the clock edge where `wr_en_i` is high. Read data is a combinational function of `addr_i`.

Top module: `multi_timer`

## Requirements
- R1: After reset, every register reads zero, no flag is pending and `irq_o` is low.
- R2: The address map is as follows. The global enable mask is at 0x00 and the pending/acknowledge register is at 0x08. Channel n (1..6) is at base 0x10*n. Its control register is at base+0x0, its tick-select register at base+0x4, its read-only count at base+0x8 and its compare value at base+0xC. Channel n uses bit n-1 of the mask and of the pending register.
- R3: In the control register, bit 0 runs the counter and bits 5:4 choose the mode: 0 one-shot, 1 repeat, 3 free-run, and 2 behaves as free-run. Bit 1 is a clear request. It zeroes the counter on the write edge and always reads back as 0.
- R4: While a channel runs, each qualified tick adds one to the count. A tick that brings the count equal to the compare value is a match and sets the channel's pending flag. After a clearing start with compare 3, the flag sets on the third tick and not before.
- R5: In repeat mode, the counter returns to 0 on a match and keeps counting, so the channel matches again after another full period.
- R6: In one-shot mode, a match clears the run bit, and the counter holds the compare value while further ticks arrive.
- R7: In free-run mode, a match sets the flag, but the counter continues past the compare value. It only wraps through 2^32.
- R8: In the tick-select register, bit 4 picks the source (0 fast tick, 1 slow tick). Bit 0 picks the divider (0 divide-by-1, 1 divide-by-2). With divide-by-2, the count advances on every second strobe counted from the last clear.
- R9: Writing the run bit to 0 freezes the count. Writing it back to 1 without the clear bit resumes counting from the frozen value.
- R10: A pending flag sets on a match whatever the enable mask holds. `irq_o` is high exactly when some channel is both pending and enabled.
- R11: Writing to the acknowledge register clears the pending flags whose bits are 1 and leaves the others unchanged. Writing 0x3F clears all six. A match in the same cycle as its acknowledge keeps the flag set.
- R12: Unused register bits read 0. Writes to unmapped offsets and to the count register have no effect, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_tick_i | input | 1 | Single-cycle strobe of the fast system tick |
| slow_tick_i | input | 1 | Single-cycle strobe of the slow real-time tick |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe, takes effect at the clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Shared interrupt, OR of pending AND enabled |

## Verification
The compare path is driven with small compare values (1, 3, 4 and 5) in each of the three modes. Sampling the count and the pending register just before and just after the matching tick separates one-shot from repeat from free-run behaviour: the count either holds, returns to zero, or runs on. Tick routing uses fast-only and slow-only strobe bursts on two channels set up differently, which shows that the source bit and the divider are decoded per channel. Acknowledge patterns with single bits and all bits, together with writes to the unmapped and read-only offsets, separate write-one-to-clear from plain writes and from decode aliasing.

// File: rtl/multi_timer_pkg.sv
// Shared constants and types for the multi-channel timer.
// Assumes byte addressing with 16-byte channel slots; slot 0 holds the global registers.
package multi_timer_pkg;

    typedef enum logic [1:0] {
        MODE_ONCE   = 2'd0,
        MODE_REPEAT = 2'd1,
        MODE_FREE_B = 2'd2,
        MODE_FREE   = 2'd3
    } run_mode_e;

    // control register fields
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_CLR_BIT  = 1;
    localparam int CTRL_MODE_LSB = 4;

    // tick-select register fields
    localparam int SEL_DIV_BIT = 0;
    localparam int SEL_SRC_BIT = 4;

    // offsets within a 16-byte slot
    localparam logic [3:0] OFF_IEN  = 4'h0;
    localparam logic [3:0] OFF_ACK  = 4'h8;
    localparam logic [3:0] OFF_CTRL = 4'h0;
    localparam logic [3:0] OFF_SEL  = 4'h4;
    localparam logic [3:0] OFF_CNT  = 4'h8;
    localparam logic [3:0] OFF_CMP  = 4'hC;

endpackage

// File: rtl/timer_tick_gen.sv
// Per-channel tick qualifier: selects the fast or slow strobe and optionally
// passes only every second strobe. Assumes both strobes are single-cycle
// pulses synchronous to clk. The halving phase restarts on a clear request.
module timer_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_tick_i,
    input  logic slow_tick_i,
    input  logic src_slow_i,
    input  logic div2_i,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);

    logic strobe;
    logic phase_q;

    // pick the configured strobe source
    assign strobe = src_slow_i ? slow_tick_i : fast_tick_i;

    // halving phase: toggles on each strobe seen while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else if (restart_i) begin
            phase_q <= 1'b0;
        end else if (run_i && strobe) begin
            phase_q <= ~phase_q;
        end
    end

    // qualified tick: every strobe, or every second one when halving
    assign tick_o = strobe && (!div2_i || phase_q);

endmodule

// File: rtl/timer_channel.sv
// One timer channel: control and tick-select state, a compare register and an
// up-counter with one-shot, repeat and free-run behaviour. A control write
// has priority over a tick in the same cycle. match_o pulses for one cycle.
module timer_channel
    import multi_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_tick_i,
    input  logic              slow_tick_i,
    input  logic              ctrl_we_i,
    input  logic              sel_we_i,
    input  logic              cmp_we_i,
    input  logic              run_wr_i,
    input  logic              clr_wr_i,
    input  logic [1:0]        mode_wr_i,
    input  logic              src_wr_i,
    input  logic              div_wr_i,
    input  logic [CNT_W-1:0]  cmp_wr_i,
    output logic [DATA_W-1:0] ctrl_rd_o,
    output logic [DATA_W-1:0] sel_rd_o,
    output logic [DATA_W-1:0] cnt_rd_o,
    output logic [DATA_W-1:0] cmp_rd_o,
    output logic              match_o
);

    logic             run_q;
    run_mode_e        mode_q;
    logic             src_q;
    logic             div2_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             restart;
    logic             tick;
    logic             step;
    logic             hit;

    assign restart = ctrl_we_i && clr_wr_i;

    timer_tick_gen i_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .fast_tick_i(fast_tick_i),
        .slow_tick_i(slow_tick_i),
        .src_slow_i (src_q),
        .div2_i     (div2_q),
        .run_i      (run_q && !ctrl_we_i),
        .restart_i  (restart),
        .tick_o     (tick)
    );

    assign cnt_inc = cnt_q + 1'b1;
    assign step    = run_q && tick && !ctrl_we_i;
    assign hit     = step && (cnt_inc == cmp_q);
    assign match_o = hit;

    // run bit and mode: written by software, run dropped by a one-shot match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            mode_q <= MODE_ONCE;
        end else if (ctrl_we_i) begin
            run_q  <= run_wr_i;
            mode_q <= run_mode_e'(mode_wr_i);
        end else if (hit && mode_q == MODE_ONCE) begin
            run_q  <= 1'b0;
        end
    end

    // tick source and divider selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= 1'b0;
            div2_q <= 1'b0;
        end else if (sel_we_i) begin
            src_q  <= src_wr_i;
            div2_q <= div_wr_i;
        end
    end

    // compare value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (cmp_we_i) begin
            cmp_q <= cmp_wr_i;
        end
    end

    // counter: clear, count, or restart on a repeat-mode match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= (hit && mode_q == MODE_REPEAT) ? '0 : cnt_inc;
        end
    end

    // read-back images, unused bits zero
    always_comb begin
        ctrl_rd_o                        = '0;
        ctrl_rd_o[CTRL_RUN_BIT]          = run_q;
        ctrl_rd_o[CTRL_MODE_LSB +: 2]    = mode_q;
        sel_rd_o                         = '0;
        sel_rd_o[SEL_DIV_BIT]            = div2_q;
        sel_rd_o[SEL_SRC_BIT]            = src_q;
        cnt_rd_o                         = DATA_W'(cnt_q);
        cmp_rd_o                         = DATA_W'(cmp_q);
    end

endmodule

// File: rtl/multi_timer.sv
// Multi-channel timer top: address decode, global interrupt enable mask,
// pending flags with write-one-to-acknowledge, read mux and interrupt OR.
// Assumes NUM_CH+1 slots fit in the address range, NUM_CH <= DATA_W and
// CNT_W <= DATA_W. Read data is combinational from addr_i.
module multi_timer
    import multi_timer_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_tick_i,
    input  logic              slow_tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    localparam int SLOT_W = ADDR_W - 4;

    logic [SLOT_W-1:0] slot;
    logic [3:0]        off;
    logic              glob_sel;
    logic [NUM_CH-1:0] ien_q;
    logic [NUM_CH-1:0] pend_q;
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] ack_mask;
    logic [DATA_W-1:0] ctrl_rd [NUM_CH];
    logic [DATA_W-1:0] sel_rd  [NUM_CH];
    logic [DATA_W-1:0] cnt_rd  [NUM_CH];
    logic [DATA_W-1:0] cmp_rd  [NUM_CH];

    assign slot     = addr_i[ADDR_W-1:4];
    assign off      = addr_i[3:0];
    assign glob_sel = (slot == '0);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic here;
        assign here = wr_en_i && (slot == SLOT_W'(g + 1));

        timer_channel #(
            .CNT_W (CNT_W),
            .DATA_W(DATA_W)
        ) i_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .fast_tick_i(fast_tick_i),
            .slow_tick_i(slow_tick_i),
            .ctrl_we_i  (here && off == OFF_CTRL),
            .sel_we_i   (here && off == OFF_SEL),
            .cmp_we_i   (here && off == OFF_CMP),
            .run_wr_i   (wdata_i[CTRL_RUN_BIT]),
            .clr_wr_i   (wdata_i[CTRL_CLR_BIT]),
            .mode_wr_i  (wdata_i[CTRL_MODE_LSB +: 2]),
            .src_wr_i   (wdata_i[SEL_SRC_BIT]),
            .div_wr_i   (wdata_i[SEL_DIV_BIT]),
            .cmp_wr_i   (wdata_i[CNT_W-1:0]),
            .ctrl_rd_o  (ctrl_rd[g]),
            .sel_rd_o   (sel_rd[g]),
            .cnt_rd_o   (cnt_rd[g]),
            .cmp_rd_o   (cmp_rd[g]),
            .match_o    (hit[g])
        );
    end

    assign ack_mask = (wr_en_i && glob_sel && off == OFF_ACK) ? wdata_i[NUM_CH-1:0] : '0;

    // global interrupt enable mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= '0;
        end else if (wr_en_i && glob_sel && off == OFF_IEN) begin
            ien_q <= wdata_i[NUM_CH-1:0];
        end
    end

    // pending flags: a match sets, an acknowledge one clears, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~ack_mask) | hit;
        end
    end

    assign irq_o = |(pend_q & ien_q);

    // read mux over global and channel slots
    always_comb begin
        rdata_o = '0;
        if (glob_sel) begin
            if (off == OFF_IEN) rdata_o[NUM_CH-1:0] = ien_q;
            if (off == OFF_ACK) rdata_o[NUM_CH-1:0] = pend_q;
        end
        for (int k = 0; k < NUM_CH; k++) begin
            if (slot == SLOT_W'(k + 1)) begin
                case (off)
                    OFF_CTRL: rdata_o = ctrl_rd[k];
                    OFF_SEL:  rdata_o = sel_rd[k];
                    OFF_CNT:  rdata_o = cnt_rd[k];
                    OFF_CMP:  rdata_o = cmp_rd[k];
                    default:  ;
                endcase
            end
        end
    end

endmodule

// File: rtl/multi_timer_chk.sv
// Property checker for multi_timer, attached by bind. Observes the bus,
// the interrupt line, the pending and enable registers and channel 1's count.
module multi_timer_chk #(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic              clr_bit_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              irq_o,
    input logic [NUM_CH-1:0] pend_q,
    input logic [NUM_CH-1:0] ien_q,
    input logic [DATA_W-1:0] cnt_first
);

    // R11
    pend_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && addr_i == ADDR_W'(8'h08)) |=> (($past(pend_q) & ~pend_q) == '0));

    // R10
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_q != '0 && ien_q != '0));

    // R3
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i[3:0] == 4'h0 && addr_i[ADDR_W-1:4] != '0) |-> (rdata_o[1] == 1'b0));

    // R3
    clr_zeroes_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(8'h10) && clr_bit_i) |=> (cnt_first == '0));

    // R12
    hole_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_W'(8'h04)) |-> (rdata_o == '0));

endmodule

bind multi_timer multi_timer_chk #(
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) i_multi_timer_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .clr_bit_i(wdata_i[1]),
    .rdata_o  (rdata_o),
    .irq_o    (irq_o),
    .pend_q   (pend_q),
    .ien_q    (ien_q),
    .cnt_first(cnt_rd[0])
);

// File: tb/test_multi_timer.sv
// Directed bench for multi_timer: one task per scenario, inputs driven and
// outputs sampled at the falling edge.
module test_multi_timer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fast_tick;
    logic        slow_tick;
    logic [7:0]  addr;
    logic        wr_en;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    multi_timer i_multi_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .fast_tick_i(fast_tick),
        .slow_tick_i(slow_tick),
        .addr_i     (addr),
        .wr_en_i    (wr_en),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .irq_o      (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic fast(input int n);
        for (int i = 0; i < n; i++) begin
            fast_tick = 1'b1;
            @(negedge clk);
            fast_tick = 1'b0;
        end
    endtask

    task automatic slow(input int n);
        for (int i = 0; i < n; i++) begin
            slow_tick = 1'b1;
            @(negedge clk);
            slow_tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        rd_chk("R1 enable mask", 8'h00, 32'h0);
        rd_chk("R1 pending", 8'h08, 32'h0);
        rd_chk("R1 ch1 control", 8'h10, 32'h0);
        rd_chk("R1 ch1 count", 8'h18, 32'h0);
        rd_chk("R1 ch6 compare", 8'h6C, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_repeat;
        wr(8'h1C, 32'd3);
        wr(8'h10, 32'h13);
        fast(2);
        rd_chk("R4 count before match", 8'h18, 32'd2);
        rd_chk("R4 no early match", 8'h08, 32'h0);
        fast(1);
        rd_chk("R4 match after 3 ticks", 8'h08, 32'h1);
        rd_chk("R5 repeat restarts", 8'h18, 32'h0);
        chk("R10 masked irq", {31'b0, irq}, 32'h0);
        rd_chk("R3 clear reads 0", 8'h10, 32'h11);
        wr(8'h00, 32'h1);
        chk("R10 irq when enabled", {31'b0, irq}, 32'h1);
        wr(8'h08, 32'h1);
        rd_chk("R11 ack clears", 8'h08, 32'h0);
        chk("R11 irq drops", {31'b0, irq}, 32'h0);
        fast(3);
        rd_chk("R5 second period", 8'h08, 32'h1);
        wr(8'h08, 32'h1);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_freeze;
        fast(1);
        wr(8'h10, 32'h10);
        fast(2);
        rd_chk("R9 frozen count", 8'h18, 32'd1);
        wr(8'h10, 32'h11);
        fast(1);
        rd_chk("R9 resumed count", 8'h18, 32'd2);
        wr(8'h10, 32'h0);
    endtask

    task automatic t_oneshot;
        wr(8'h2C, 32'd4);
        wr(8'h20, 32'h03);
        fast(4);
        rd_chk("R6 match pending", 8'h08, 32'h2);
        rd_chk("R6 run cleared", 8'h20, 32'h0);
        fast(2);
        rd_chk("R6 count held", 8'h28, 32'd4);
        wr(8'h08, 32'h3F);
    endtask

    task automatic t_freerun;
        wr(8'h3C, 32'd5);
        wr(8'h30, 32'h33);
        fast(5);
        rd_chk("R7 match pending", 8'h08, 32'h4);
        rd_chk("R7 count at match", 8'h38, 32'd5);
        fast(2);
        rd_chk("R7 counts past compare", 8'h38, 32'd7);
        rd_chk("R7 still running", 8'h30, 32'h31);
        wr(8'h30, 32'h0);
        wr(8'h08, 32'h3F);
    endtask

    task automatic t_ticksel;
        wr(8'h44, 32'h01);
        wr(8'h4C, 32'd100);
        wr(8'h40, 32'h33);
        wr(8'h54, 32'h10);
        wr(8'h5C, 32'd100);
        wr(8'h50, 32'h33);
        fast(4);
        rd_chk("R8 halved fast count", 8'h48, 32'd2);
        rd_chk("R8 slow ignores fast", 8'h58, 32'd0);
        slow(3);
        rd_chk("R8 slow count", 8'h58, 32'd3);
        rd_chk("R8 fast ignores slow", 8'h48, 32'd2);
        rd_chk("R8 select readback", 8'h54, 32'h10);
        wr(8'h40, 32'h0);
        wr(8'h50, 32'h0);
    endtask

    task automatic t_ack;
        wr(8'h6C, 32'd1);
        wr(8'h60, 32'h03);
        wr(8'h1C, 32'd1);
        wr(8'h10, 32'h03);
        fast(1);
        rd_chk("R11 two pending", 8'h08, 32'h21);
        wr(8'h08, 32'h01);
        rd_chk("R11 partial ack", 8'h08, 32'h20);
        wr(8'h08, 32'h3F);
        rd_chk("R11 ack all", 8'h08, 32'h0);
    endtask

    task automatic t_unmapped;
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk("R12 hole reads 0", 8'h04, 32'h0);
        wr(8'h70, 32'hFFFF_FFFF);
        rd_chk("R12 slot 7 reads 0", 8'h70, 32'h0);
        wr(8'h18, 32'h1234);
        rd_chk("R12 count not writable", 8'h18, 32'd1);
        wr(8'h10, 32'hFFFF_FFFC);
        rd_chk("R12 control unused bits", 8'h10, 32'h30);
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R12 mask unused bits", 8'h00, 32'h3F);
        rd_chk("R2 ch2 compare", 8'h2C, 32'd4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; fast_tick = 1'b0; slow_tick = 1'b0;
        addr = '0; wr_en = 1'b0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_repeat();
        t_freeze();
        t_oneshot();
        t_freerun();
        t_ticksel();
        t_ack();
        t_unmapped();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule